// File: doc/BRIEF.md
# Symmetric Pipelined Transposed FIR Filter

This block is an 11-tap (order 10) FIR filter built in transposed form. Each accepted signed sample is multiplied by every distinct coefficient in the same cycle. The partial sums travel through a chain of accumulation registers, so the raw input is never delayed. The coefficients are mirror-symmetric, with h[k] equal to h[10-k]. Only six products are formed, and each one feeds both taps that share its coefficient.

A register stage sits between the multiplier bank and the adder chain. Each register-to-register path therefore holds either one multiply or one add, never both. The result is kept at full precision on a 36-bit output. Each accepted sample produces exactly one output sample, and the output sequence equals the direct-form convolution of the input stream with h.

Samples enter and leave over valid/ready streams. A sample moves in on a clock edge where `in_valid` and `in_ready` are both high. A result moves out on an edge where `out_valid` and `out_ready` are both high. While a result waits, it holds still. When the output register is full and not being taken, and the product stage is also full, `in_ready` drops. `in_ready` depends combinationally on `out_ready`.

Top module: `sym_fir_top`

## Requirements
- R1: A synchronous active-high reset clears the product stage, the partial sums and the output. After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A single sample of value 1 followed by zeros yields the outputs h[0] through h[10] in that order. The default coefficients are h[0..5] = -7, 19, -58, 130, -301, 1024, and h[10-k] = h[k].
- R3: Each output equals the sum over j = 0..10 of h[j]·x[n-j]. Samples from before reset count as zero. This holds for steps and random data, including the input value -32768.
- R4: With `out_ready` high, a sample accepted on clock edge t shows up with `out_valid` high right after edge t+1.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R6: While the output is stalled and the product stage is full, `in_ready` is 0. No sample is lost or duplicated, and every accepted sample yields exactly one output.
- R7: Cycles with no accepted sample do not advance the filter state. Gaps in `in_valid` leave the results unchanged.
- R8: The output is the full 36-bit two's complement sum, with no truncation. This includes the inputs that give the largest magnitude sum.
- R9: A reset in the middle of a stream discards pending results and history. The next impulse again yields h[0..10].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Filter can take a sample this cycle |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output this cycle |
| out_data | output | 36 | Signed filtered sample |

## Verification
Some rules are checked by assertions on every cycle:
- the reset clearing;
- a stalled output holding still;
- `in_ready` dropping while both stages are full;
- the one-cycle gap between acceptance and the first valid output;
- the product and result registers staying frozen when nothing advances.

The numerical behaviour can only be shown by the bench's scenarios. These cover the impulse response order, convolution over steps, random and full-scale data, freedom from loss under back-pressure, immunity to input gaps, and the clearing of history by a mid-stream reset. In each case the outputs are compared against an independent direct-form model.

// File: rtl/sym_fir_pkg.sv
package sym_fir_pkg;

  localparam int DEF_TAPS = 11;
  localparam int DEF_XW   = 16;
  localparam int DEF_CW   = 16;
  localparam int DEF_AW   = 36;

  // index of the distinct product that serves chain position k
  function automatic int mirror_idx(input int k, input int taps);
    return (k < (taps - 1 - k)) ? k : (taps - 1 - k);
  endfunction

endpackage

// File: rtl/sym_fir_flow.sv
module sym_fir_flow (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic load,
  output logic adv,
  output logic out_valid
);

  logic prod_full;

  assign adv      = prod_full && (!out_valid || out_ready);
  assign in_ready = !prod_full || adv;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_full <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (load)      prod_full <= 1'b1;
      else if (adv)  prod_full <= 1'b0;
      if (adv)            out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !prod_full)); // R1

  AST_FIRST_OUT: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(load, 2)); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid); // R5

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (prod_full && out_valid && !out_ready) |-> !in_ready); // R6

endmodule

// File: rtl/sym_fir_prod.sv
module sym_fir_prod #(
  parameter int NUNIQ = 6,
  parameter int XW    = 16,
  parameter int CW    = 16,
  parameter int PW    = XW + CW,
  parameter logic [NUNIQ*CW-1:0] COEFS = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [XW-1:0]       x_in,
  output logic [NUNIQ*PW-1:0] prod_flat
);

  logic signed [XW-1:0] xs;
  assign xs = $signed(x_in);

  for (genvar j = 0; j < NUNIQ; j++) begin : g_mul
    localparam logic signed [CW-1:0] COEF = COEFS[j*CW +: CW];
    logic signed [PW-1:0] p_q;
    always_ff @(posedge clk) begin
      if (rst)       p_q <= '0;
      else if (load) p_q <= xs * COEF;
    end
    assign prod_flat[j*PW +: PW] = p_q;
  end

  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(prod_flat)); // R7

endmodule

// File: rtl/sym_fir_chain.sv
module sym_fir_chain #(
  parameter int TAPS  = 11,
  parameter int PW    = 32,
  parameter int AW    = 36,
  localparam int NUNIQ = (TAPS + 1) / 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic [NUNIQ*PW-1:0] prod_flat,
  output logic [AW-1:0]       y
);

  logic signed [AW-1:0] pe  [NUNIQ];
  logic signed [AW-1:0] acc [1:TAPS-1];
  logic signed [AW-1:0] y_q;

  for (genvar j = 0; j < NUNIQ; j++) begin : g_ext
    assign pe[j] = {{(AW-PW){prod_flat[j*PW+PW-1]}}, prod_flat[j*PW +: PW]};
  end

  for (genvar k = 1; k < TAPS; k++) begin : g_acc
    localparam int M = sym_fir_pkg::mirror_idx(k, TAPS);
    if (k == TAPS - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (rst)      acc[k] <= '0;
        else if (adv) acc[k] <= pe[M];
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst)      acc[k] <= '0;
        else if (adv) acc[k] <= pe[M] + acc[k+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      y_q <= '0;
    else if (adv) y_q <= pe[0] + acc[1];
  end

  assign y = y_q;

  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(y_q)); // R7

endmodule

// File: rtl/sym_fir_top.sv
module sym_fir_top #(
  parameter int TAPS = sym_fir_pkg::DEF_TAPS,
  parameter int XW   = sym_fir_pkg::DEF_XW,
  parameter int CW   = sym_fir_pkg::DEF_CW,
  parameter int AW   = sym_fir_pkg::DEF_AW,
  localparam int NUNIQ = (TAPS + 1) / 2,
  localparam int PW    = XW + CW,
  // h[0] in the low slice; h[TAPS-1-k] mirrors h[k]
  parameter logic [NUNIQ*CW-1:0] COEFS =
    {16'h0400, 16'hFED3, 16'h0082, 16'hFFC6, 16'h0013, 16'hFFF9}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [XW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_data
);

  logic                load;
  logic                adv;
  logic [NUNIQ*PW-1:0] prod_flat;

  sym_fir_flow u_flow (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .load      (load),
    .adv       (adv),
    .out_valid (out_valid)
  );

  sym_fir_prod #(
    .NUNIQ (NUNIQ),
    .XW    (XW),
    .CW    (CW),
    .PW    (PW),
    .COEFS (COEFS)
  ) u_prod (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .x_in      (in_data),
    .prod_flat (prod_flat)
  );

  sym_fir_chain #(
    .TAPS (TAPS),
    .PW   (PW),
    .AW   (AW)
  ) u_chain (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .prod_flat (prod_flat),
    .y         (out_data)
  );

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data)); // R5

endmodule

// File: tb/tb_sym_fir_top.sv
module tb_sym_fir_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [35:0] out_data;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  longint H [11];
  longint hist [11];
  longint q [$];

  always #4 clk = ~clk;

  sym_fir_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: sampled shortly before each rising edge
  always begin
    @(negedge clk); #2;
    if (rst) begin
      for (int i = 0; i < 11; i++) hist[i] = 0;
      q.delete();
    end else begin
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk(1'b0, "R6", $signed(out_data), 0);
        else begin
          longint e;
          longint a;
          e = q.pop_front();
          a = $signed(out_data);
          chk(a == e, cur_req, a, e);
        end
      end
      if (in_valid && in_ready) begin
        longint s;
        for (int i = 10; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = $signed(in_data);
        s = 0;
        for (int i = 0; i < 11; i++) s += H[i] * hist[i];
        q.push_back(s);
      end
    end
  end

  // all tasks start and end just after a falling edge
  task automatic send(input logic [15:0] x);
    bit acc;
    in_valid = 1'b1;
    in_data  = x;
    do begin
      #2 acc = in_ready;
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (q.size() != 0 && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    cur_req = "R1";
    do_reset();
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
  endtask

  task automatic t_impulse(input string req);
    cur_req = req;
    send(16'd1);
    for (int i = 0; i < 12; i++) send(16'd0);
    drain();
  endtask

  task automatic t_latency();
    cur_req = "R4";
    in_valid = 1'b1; in_data = 16'd5;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R4", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R4", out_valid, 1);
    drain();
  endtask

  task automatic t_step();
    cur_req = "R3";
    for (int i = 0; i < 20; i++) send(16'd1000);
    drain();
  endtask

  task automatic t_random();
    cur_req = "R3";
    for (int i = 0; i < 60; i++) begin
      if (i % 7 == 3) send(16'h8000);
      else send(16'($urandom));
    end
    drain();
  endtask

  task automatic t_fullscale();
    cur_req = "R8";
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 11; i++) send((H[10-i] > 0) ? 16'h8000 : 16'h7FFF);
      for (int i = 0; i < 11; i++) send((H[10-i] > 0) ? 16'h7FFF : 16'h8000);
    end
    drain();
  endtask

  task automatic t_gaps();
    cur_req = "R7";
    for (int i = 0; i < 25; i++) begin
      send(16'(i * 977 - 9000));
      repeat (i % 4) @(negedge clk);
      out_ready = (i % 3 != 1);
    end
    out_ready = 1'b1;
    drain();
  endtask

  task automatic t_backpressure();
    logic [35:0] d0;
    cur_req = "R5";
    out_ready = 1'b0;
    fork
      begin
        send(16'd300); send(16'hFF00); send(16'd77); send(16'd12);
      end
    join_none
    repeat (3) @(negedge clk);
    d0 = out_data;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R5", out_valid, 1);
      chk(out_data == d0, "R5", $signed(out_data), $signed(d0));
      chk(in_ready == 1'b0, "R6", in_ready, 0);
    end
    out_ready = 1'b1;
    wait fork;
    cur_req = "R6";
    drain();
    chk(q.size() == 0, "R6", q.size(), 0);
  endtask

  task automatic t_midreset();
    cur_req = "R9";
    for (int i = 0; i < 5; i++) send(16'd2000 + 16'(i));
    do_reset();
    chk(out_valid == 1'b0, "R9", out_valid, 0);
    t_impulse("R9");
  endtask

  initial begin
    longint hu [6] = '{-7, 19, -58, 130, -301, 1024};
    for (int k = 0; k < 11; k++) H[k] = hu[(k < 10 - k) ? k : 10 - k];
    @(negedge clk);
    t_reset();
    t_impulse("R2");
    t_latency();
    t_step();
    t_random();
    t_fullscale();
    t_gaps();
    t_backpressure();
    t_midreset();
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R6", q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule